// File: doc/BRIEF.md
# Phoneline Pulse-Position Symbol Transmitter

This block converts a stream of small symbol values into timed pulse bursts on two line outputs, one positive and one negative, for a home phoneline physical layer. Each accepted symbol produces a burst of narrow pulses. The pulse width is counted in fast oscillator cycles. The burst is followed by a quiet gap whose length carries the symbol value by pulse position. The gap is counted in slow ticks, and one slow tick spans seven oscillator cycles.

Software-style settings arrive through a one-byte register port with a write strobe and a 3-bit selector. These settings are pulse width, pulse counts per line, three blanking lengths and a mode byte. They land in shadow registers. The sequencer snapshots the values it needs only when it accepts a symbol, so a write never disturbs a burst or gap in progress. Symbols enter through a valid/ready handshake, and a busy flag covers the whole burst plus gap.

Top module: `plpm_sym_tx`

## Requirements
- R1: While reset is held and after it is released, `sym_ready`=1, `busy`=0, and both lines are low. The register defaults are: width 4, count 0x44, fast blank 0x1C, slow blank 0x2C, announce blank 0x40, announce spacing 0x14, mode 0.
- R2: Selector 0 sets the pulse width W in oscillator cycles. Each pulse is high for exactly W cycles, and consecutive pulses of a burst are separated by exactly W low cycles. W=0 sends no pulses.
- R3: Selector 1 sets the pulse counts. Bits 7:4 give the number of positive-line pulses and bits 3:0 give the number of negative-line pulses. All positive pulses come before any negative pulse, and the first pulse starts in the cycle after acceptance.
- R4: `line_p` and `line_n` are never high in the same cycle.
- R5: After the last pulse, or straight after acceptance if there are no pulses, the block stays busy with both lines low while it counts N slow ticks, where N = base + symbol value. The busy-quiet stretch lasts 1 cycle when N=0 and 7N-5 to 7N+1 cycles otherwise.
- R6: Mode bit 0 (selector 6) picks the base. A value of 1 uses the fast blank (selector 2) and 0 uses the slow blank (selector 3).
- R7: Mode bit 1 (selector 6) selects announce mode, which overrides bit 0. The base then becomes announce blank (selector 4) plus announce spacing (selector 5).
- R8: `sym_ready` is high exactly when `busy` is low. A symbol is taken only on a cycle with `sym_valid` and `sym_ready` both high. Without `sym_valid` the block stays idle.
- R9: A register write made while busy leaves the current symbol's burst and gap unchanged. The new value applies from the next accepted symbol.
- R10: A write with selector 7 changes nothing.
- R11: A count nibble of 0 sends no pulses on that line. With both nibbles 0, the block goes straight from acceptance to the gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register selector |
| cfg_wdata | input | 8 | Register write data |
| sym_valid | input | 1 | Symbol offered |
| sym_data | input | SYM_W | Symbol value |
| sym_ready | output | 1 | Block can take a symbol |
| busy | output | 1 | Burst or gap in progress |
| line_p | output | 1 | Positive line pulse |
| line_n | output | 1 | Negative line pulse |

## Verification
Several properties are checked by assertions on every cycle. These are line exclusivity, the rule that a started pulse holds until its width count expires, the rule that no positive pulse follows a negative one, the freezing of the snapshot while busy, and the spacing between slow ticks. Exact burst shapes, gap lengths under each base selection, deferred register writes, and ignored selectors show up only in the bench's scenarios. There the bench compares every sampled line value and the quiet-stretch length against its own model, across directed extremes (width 0 and 255, count 0x00, 0x0F, 0xF0 and 0xFF, gap 0 and the largest announce gap) and seeded random settings.

// File: rtl/plpm_pkg.sv
package plpm_pkg;

  localparam int REG_W = 8;
  localparam int NIB_W = 4;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PULSE = 2'd1,
    ST_SPACE = 2'd2,
    ST_GAP   = 2'd3
  } seq_state_e;

  localparam logic [2:0] SEL_WIDTH     = 3'd0;
  localparam logic [2:0] SEL_COUNT     = 3'd1;
  localparam logic [2:0] SEL_BLANK_HI  = 3'd2;
  localparam logic [2:0] SEL_BLANK_LO  = 3'd3;
  localparam logic [2:0] SEL_BLANK_ANN = 3'd4;
  localparam logic [2:0] SEL_ANN_SPACE = 3'd5;
  localparam logic [2:0] SEL_MODE      = 3'd6;

  localparam logic [REG_W-1:0] RST_WIDTH     = 8'h04;
  localparam logic [REG_W-1:0] RST_COUNT     = 8'h44;
  localparam logic [REG_W-1:0] RST_BLANK_HI  = 8'h1C;
  localparam logic [REG_W-1:0] RST_BLANK_LO  = 8'h2C;
  localparam logic [REG_W-1:0] RST_BLANK_ANN = 8'h40;
  localparam logic [REG_W-1:0] RST_ANN_SPACE = 8'h14;
  localparam logic [1:0]       RST_MODE      = 2'b00;

endpackage

// File: rtl/plpm_tick_div.sv
module plpm_tick_div #(
  parameter int DIV_N = 7
) (
  input  logic clk,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int CW = (DIV_N > 1) ? $clog2(DIV_N) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV_N - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q + 1'b1;
    if (cnt_q == LAST) cnt_d = '0;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign tick_o = (cnt_q == LAST);

  AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_ni)
    tick_o |=> !tick_o); // R5

endmodule

// File: rtl/plpm_cfg_regs.sv
module plpm_cfg_regs
  import plpm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [2:0]       sel_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] width_o,
  output logic [NIB_W-1:0] pos_cnt_o,
  output logic [NIB_W-1:0] neg_cnt_o,
  output logic [REG_W:0]   base_o
);
  localparam int NREG = 7;

  logic [NREG-1:0]       wen;
  logic [REG_W-1:0]      shadow_q [NREG];
  logic [REG_W-1:0]      shadow_d [NREG];
  logic [REG_W-1:0]      rst_val  [NREG];

  assign rst_val[SEL_WIDTH]     = RST_WIDTH;
  assign rst_val[SEL_COUNT]     = RST_COUNT;
  assign rst_val[SEL_BLANK_HI]  = RST_BLANK_HI;
  assign rst_val[SEL_BLANK_LO]  = RST_BLANK_LO;
  assign rst_val[SEL_BLANK_ANN] = RST_BLANK_ANN;
  assign rst_val[SEL_ANN_SPACE] = RST_ANN_SPACE;
  assign rst_val[SEL_MODE]      = {{(REG_W-2){1'b0}}, RST_MODE};

  genvar gi;
  generate
    for (gi = 0; gi < NREG; gi++) begin : g_reg
      assign wen[gi] = wr_i && (sel_i == 3'(gi));

      always_comb begin
        shadow_d[gi] = shadow_q[gi];
        if (wen[gi]) shadow_d[gi] = wdata_i;
      end

      always_ff @(posedge clk or negedge rst_ni) begin
        if (!rst_ni) shadow_q[gi] <= rst_val[gi];
        else         shadow_q[gi] <= shadow_d[gi];
      end
    end
  endgenerate

  logic fast_sel, ann_sel;
  assign fast_sel = shadow_q[SEL_MODE][0];
  assign ann_sel  = shadow_q[SEL_MODE][1];

  assign width_o   = shadow_q[SEL_WIDTH];
  assign pos_cnt_o = shadow_q[SEL_COUNT][2*NIB_W-1:NIB_W];
  assign neg_cnt_o = shadow_q[SEL_COUNT][NIB_W-1:0];

  always_comb begin
    if (ann_sel)
      base_o = {1'b0, shadow_q[SEL_BLANK_ANN]} + {1'b0, shadow_q[SEL_ANN_SPACE]};
    else if (fast_sel)
      base_o = {1'b0, shadow_q[SEL_BLANK_HI]};
    else
      base_o = {1'b0, shadow_q[SEL_BLANK_LO]};
  end

endmodule

// File: rtl/plpm_burst_seq.sv
module plpm_burst_seq
  import plpm_pkg::*;
#(
  parameter int SYM_W = 4
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [REG_W-1:0] width_i,
  input  logic [NIB_W-1:0] pos_cnt_i,
  input  logic [NIB_W-1:0] neg_cnt_i,
  input  logic [REG_W:0]   base_i,
  input  logic             sym_valid_i,
  input  logic [SYM_W-1:0] sym_data_i,
  output logic             sym_ready_o,
  output logic             busy_o,
  output logic             line_p_o,
  output logic             line_n_o
);
  localparam int BASE_W = REG_W + 1;
  localparam int GAP_W  = ((BASE_W > SYM_W) ? BASE_W : SYM_W) + 1;

  seq_state_e         state_q, state_d;
  logic [REG_W-1:0]   wid_q, wid_d;
  logic [REG_W-1:0]   wcnt_q, wcnt_d;
  logic [NIB_W-1:0]   pleft_q, pleft_d;
  logic [NIB_W-1:0]   nleft_q, nleft_d;
  logic [GAP_W-1:0]   gcnt_q, gcnt_d;

  logic               accept;
  logic               has_pulse;
  logic [NIB_W:0]     remain;

  assign accept    = sym_valid_i && (state_q == ST_IDLE);
  assign has_pulse = (width_i != '0) && ((pos_cnt_i != '0) || (neg_cnt_i != '0));
  assign remain    = {1'b0, pleft_q} + {1'b0, nleft_q} - 1'b1;

  always_comb begin
    state_d = state_q;
    wid_d   = wid_q;
    wcnt_d  = wcnt_q;
    pleft_d = pleft_q;
    nleft_d = nleft_q;
    gcnt_d  = gcnt_q;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          wid_d   = width_i;
          wcnt_d  = width_i - 1'b1;
          pleft_d = (width_i != '0) ? pos_cnt_i : '0;
          nleft_d = (width_i != '0) ? neg_cnt_i : '0;
          gcnt_d  = GAP_W'(base_i) + GAP_W'(sym_data_i);
          state_d = has_pulse ? ST_PULSE : ST_GAP;
        end
      end
      ST_PULSE: begin
        if (wcnt_q == '0) begin
          if (pleft_q != '0) pleft_d = pleft_q - 1'b1;
          else               nleft_d = nleft_q - 1'b1;
          if (remain != '0) begin
            state_d = ST_SPACE;
            wcnt_d  = wid_q - 1'b1;
          end else begin
            state_d = ST_GAP;
          end
        end else begin
          wcnt_d = wcnt_q - 1'b1;
        end
      end
      ST_SPACE: begin
        if (wcnt_q == '0) begin
          state_d = ST_PULSE;
          wcnt_d  = wid_q - 1'b1;
        end else begin
          wcnt_d = wcnt_q - 1'b1;
        end
      end
      ST_GAP: begin
        if (gcnt_q == '0)  state_d = ST_IDLE;
        else if (tick_i)   gcnt_d  = gcnt_q - 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      wid_q   <= '0;
      wcnt_q  <= '0;
      pleft_q <= '0;
      nleft_q <= '0;
      gcnt_q  <= '0;
    end else begin
      state_q <= state_d;
      wid_q   <= wid_d;
      wcnt_q  <= wcnt_d;
      pleft_q <= pleft_d;
      nleft_q <= nleft_d;
      gcnt_q  <= gcnt_d;
    end
  end

  assign sym_ready_o = (state_q == ST_IDLE);
  assign busy_o      = (state_q != ST_IDLE);
  assign line_p_o    = (state_q == ST_PULSE) && (pleft_q != '0);
  assign line_n_o    = (state_q == ST_PULSE) && (pleft_q == '0);

  AST_LINES_EXCL: assert property (@(posedge clk) disable iff (!rst_ni)
    !(line_p_o && line_n_o)); // R4
  AST_PULSE_HELD: assert property (@(posedge clk) disable iff (!rst_ni)
    (state_q == ST_PULSE && wcnt_q != '0) |=> (state_q == ST_PULSE)); // R2
  AST_POS_FIRST: assert property (@(posedge clk) disable iff (!rst_ni)
    (line_n_o && busy_o) |=> !line_p_o); // R3
  AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (!rst_ni)
    busy_o |=> $stable(wid_q)); // R9
  AST_GAP_WAIT: assert property (@(posedge clk) disable iff (!rst_ni)
    (state_q == ST_GAP && gcnt_q != '0) |=> (state_q == ST_GAP)); // R5

endmodule

// File: rtl/plpm_sym_tx.sv
module plpm_sym_tx
  import plpm_pkg::*;
#(
  parameter int SYM_W = 4,
  parameter int DIV_N = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [2:0]       cfg_sel,
  input  logic [REG_W-1:0] cfg_wdata,
  input  logic             sym_valid,
  input  logic [SYM_W-1:0] sym_data,
  output logic             sym_ready,
  output logic             busy,
  output logic             line_p,
  output logic             line_n
);
  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic             tick;
  logic [REG_W-1:0] width;
  logic [NIB_W-1:0] pos_cnt, neg_cnt;
  logic [REG_W:0]   base;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  plpm_tick_div #(.DIV_N(DIV_N)) u_div (
    .clk    (clk),
    .rst_ni (rst_int_n),
    .tick_o (tick)
  );

  plpm_cfg_regs u_cfg (
    .clk       (clk),
    .rst_ni    (rst_int_n),
    .wr_i      (cfg_wr),
    .sel_i     (cfg_sel),
    .wdata_i   (cfg_wdata),
    .width_o   (width),
    .pos_cnt_o (pos_cnt),
    .neg_cnt_o (neg_cnt),
    .base_o    (base)
  );

  plpm_burst_seq #(.SYM_W(SYM_W)) u_seq (
    .clk         (clk),
    .rst_ni      (rst_int_n),
    .tick_i      (tick),
    .width_i     (width),
    .pos_cnt_i   (pos_cnt),
    .neg_cnt_i   (neg_cnt),
    .base_i      (base),
    .sym_valid_i (sym_valid),
    .sym_data_i  (sym_data),
    .sym_ready_o (sym_ready),
    .busy_o      (busy),
    .line_p_o    (line_p),
    .line_n_o    (line_n)
  );

endmodule

// File: tb/plpm_sym_tx_tb.sv
module plpm_sym_tx_tb_top;
  localparam int SYM_W = 4;
  localparam int DIV_N = 7;

  logic clk = 1'b0;
  logic rst_n;
  logic cfg_wr;
  logic [2:0] cfg_sel;
  logic [7:0] cfg_wdata;
  logic sym_valid;
  logic [SYM_W-1:0] sym_data;
  logic sym_ready, busy, line_p, line_n;

  int checks = 0;
  int errors = 0;

  // bench model of the register shadows
  int m_width = 4, m_count = 'h44, m_bhi = 'h1C, m_blo = 'h2C;
  int m_bann = 'h40, m_aspc = 'h14, m_mode = 0;

  always #4 clk = ~clk;

  plpm_sym_tx #(.SYM_W(SYM_W), .DIV_N(DIV_N)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .sym_valid(sym_valid), .sym_data(sym_data),
    .sym_ready(sym_ready), .busy(busy), .line_p(line_p), .line_n(line_n)
  );

  function automatic int model_base();
    if (m_mode & 2)      return m_bann + m_aspc;
    else if (m_mode & 1) return m_bhi;
    else                 return m_blo;
  endfunction

  function automatic logic [1:0] exp_bits(int i, int p, int w);
    int unit = i / w;
    if (unit % 2 == 1) return 2'b00;
    return ((unit / 2) < p) ? 2'b10 : 2'b01;
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic model_write(input int sel, input int data);
    case (sel)
      0: m_width = data;
      1: m_count = data;
      2: m_bhi   = data;
      3: m_blo   = data;
      4: m_bann  = data;
      5: m_aspc  = data;
      6: m_mode  = data & 3;
      default: ;
    endcase
  endtask

  task automatic wr(input int sel, input int data);
    cfg_wr = 1'b1; cfg_sel = 3'(sel); cfg_wdata = 8'(data);
    @(negedge clk);
    cfg_wr = 1'b0;
    model_write(sel, data);
  endtask

  task automatic send_sym(input int sym, input bit mid_wr, input int msel,
                          input int mdata, input string tag);
    int p, n, w, len, nt, idx, tail, lo, hi, first_bad;
    logic [1:0] got, want;
    bit bad_tail, bad_rdy, both;
    w = m_width;
    p = (w == 0) ? 0 : (m_count >> 4) & 15;
    n = (w == 0) ? 0 : m_count & 15;
    len = (p + n > 0) ? (2 * (p + n) - 1) * w : 0;
    nt = model_base() + sym;
    idx = 0; tail = 0; first_bad = -1;
    bad_tail = 0; bad_rdy = 0; both = 0; got = 2'b00; want = 2'b00;
    while (!sym_ready) @(negedge clk);
    sym_valid = 1'b1; sym_data = SYM_W'(sym);
    @(negedge clk);
    sym_valid = 1'b0;
    while (busy) begin
      if (sym_ready) bad_rdy = 1;
      if (line_p && line_n) both = 1;
      if (idx < len) begin
        if ({line_p, line_n} != exp_bits(idx, p, w) && first_bad < 0) begin
          first_bad = idx; got = {line_p, line_n}; want = exp_bits(idx, p, w);
        end
      end else begin
        tail++;
        if (line_p || line_n) bad_tail = 1;
      end
      if (mid_wr && idx == 1) begin
        cfg_wr = 1'b1; cfg_sel = 3'(msel); cfg_wdata = 8'(mdata);
      end else begin
        cfg_wr = 1'b0;
      end
      idx++;
      @(negedge clk);
    end
    if (mid_wr) begin
      cfg_wr = 1'b0;
      model_write(msel, mdata);
    end
    check(first_bad < 0, {tag, " R2 R3"}, "burst sample value", int'(got), int'(want));
    check(idx >= len, {tag, " R2 R3 R11"}, "busy cycles vs burst length", idx, len);
    if (nt == 0) begin lo = 1; hi = 1; end
    else begin lo = DIV_N * nt - 5; hi = DIV_N * nt + 1; end
    check(tail >= lo && tail <= hi && !bad_tail, {tag, " R5"},
          "quiet cycles (expected is low bound)", tail, lo);
    check(!both, {tag, " R4"}, "both lines high", int'(both), 0);
    check(!bad_rdy && sym_ready, {tag, " R8"}, "ready while busy", int'(bad_rdy), 0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 200000, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    int seed;
    seed = $urandom(32'd20240611);
    rst_n = 1'b0; cfg_wr = 1'b0; cfg_sel = '0; cfg_wdata = '0;
    sym_valid = 1'b0; sym_data = '0;
    repeat (3) @(negedge clk);
    check(sym_ready && !busy && !line_p && !line_n, "R1", "outputs in reset",
          {sym_ready, busy, line_p, line_n}, 4'b1000);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(sym_ready && !busy && !line_p && !line_n, "R1", "outputs after reset",
          {sym_ready, busy, line_p, line_n}, 4'b1000);

    // R8: no valid, stays idle
    repeat (10) @(negedge clk);
    check(!busy && sym_ready, "R8", "idle without valid", int'(busy), 0);

    // R1 defaults: slow base, count 0x44, width 4
    send_sym(0, 0, 0, 0, "R1 default sym0");
    send_sym(3, 0, 0, 0, "R1 R6 default sym3");

    // R6 fast base
    wr(6, 1);
    send_sym(5, 0, 0, 0, "R6 fast");
    // R7 announce overrides fast
    wr(6, 3);
    send_sym(2, 0, 0, 0, "R7 announce");
    wr(4, 255); wr(5, 255);
    send_sym(15, 0, 0, 0, "R7 announce max");
    wr(6, 0);

    // R11 nibble corners
    wr(1, 'h00); send_sym(1, 0, 0, 0, "R11 count 00");
    wr(1, 'h0F); send_sym(0, 0, 0, 0, "R11 count 0F");
    wr(1, 'hF0); send_sym(0, 0, 0, 0, "R11 count F0");
    wr(1, 'hFF); wr(0, 1); send_sym(4, 0, 0, 0, "R3 count FF w1");
    // R2 width corners
    wr(0, 0); send_sym(2, 0, 0, 0, "R2 width 0");
    wr(0, 255); wr(1, 'h11); send_sym(0, 0, 0, 0, "R2 width 255");

    // R5 zero gap
    wr(0, 2); wr(1, 'h21); wr(3, 0);
    send_sym(0, 0, 0, 0, "R5 gap zero");
    send_sym(1, 0, 0, 0, "R5 gap one");

    // R10 selector 7 ignored
    wr(7, 'h00);
    send_sym(1, 0, 0, 0, "R10 sel7");

    // R9 write while busy applies next symbol only
    wr(3, 6);
    send_sym(2, 1, 0, 5, "R9 during");
    send_sym(2, 0, 0, 0, "R9 after");
    send_sym(1, 1, 3, 3, "R9 gap during");
    send_sym(1, 0, 0, 0, "R9 gap after");

    // constrained random
    for (int k = 0; k < 24; k++) begin
      wr(0, $urandom_range(1, 6));
      wr(1, $urandom_range(0, 255));
      wr(2, $urandom_range(0, 12));
      wr(3, $urandom_range(0, 12));
      wr(4, $urandom_range(0, 8));
      wr(5, $urandom_range(0, 8));
      wr(6, $urandom_range(0, 3));
      send_sym($urandom_range(0, 15), 0, 0, 0, "R2 R3 R6 R7 random");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule